// File: doc/BRIEF.md
# Launch-Time Transmit Gate

This block schedules packet transmission by time. Software, or a reply engine, pushes descriptors that each carry a packet ID and a target launch time. The block holds each descriptor until the live nanosecond clock reaches that target, and then releases the descriptor with a one-cycle strobe. Descriptors leave strictly in the order they arrived. Packet data never passes through the block.

A launch time carries only the nanoseconds-within-second part. The block compares it with the live clock modulo one second. A target that lies up to half a second ahead of the clock is held. Any other target counts as due now or already past, so a target cannot alias across the second boundary. A descriptor released later than a programmable tolerance after its target is marked late rather than held.

A small combinational path forms a reply launch time. It adds a programmable constant delay to a hardware receive timestamp and wraps the sum into one second. The queue has a fixed depth. A full flag reports when the queue has no room, and a sticky overflow flag records any push that was lost.

Top module: `launch_gate`

## Requirements
- R1: After reset, rel_valid, rel_late, full and overflow are all 0.
- R2: The head descriptor is held while ahead = (target − now_ns) mod 10^9 is between 1 and 500,000,000 inclusive. This includes targets that lie across the second rollover.
- R3: When ahead is 0 or greater than 500,000,000 in a cycle, the head is popped at that clock edge. rel_valid is 1 for the following cycle, and rel_id carries that descriptor's ID.
- R4: rel_late is 1 with a release exactly when (now_ns − target) mod 10^9, taken in the popping cycle, is greater than late_tol. At a lateness equal to late_tol the flag is 0.
- R5: Descriptors are released in push order. A held head blocks every later entry, even entries whose targets have already passed.
- R6: full is 1 exactly when DEPTH descriptors are queued.
- R7: A push while full is 1 is dropped and does not reach the queue. overflow then becomes 1 and stays 1 until reset.
- R8: reply_ns equals (rx_ts_ns + reply_delay) mod 10^9 in the same cycle, for inputs below 10^9.
- R9: At most one descriptor is released per cycle. A strobe lasts one cycle unless another due descriptor follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push a descriptor this cycle |
| push_id | input | ID_W | Descriptor ID |
| push_ns | input | NS_W | Launch time, ns within second |
| now_ns | input | NS_W | Live clock, ns within second |
| late_tol | input | NS_W | Lateness tolerance in ns |
| rx_ts_ns | input | NS_W | Hardware receive timestamp, ns within second |
| reply_delay | input | NS_W | Constant reply delay in ns |
| reply_ns | output | NS_W | Reply launch time |
| rel_valid | output | 1 | Release strobe |
| rel_id | output | ID_W | Released descriptor ID |
| rel_late | output | 1 | Released descriptor was late |
| full | output | 1 | Queue holds DEPTH entries |
| overflow | output | 1 | Sticky: a push was dropped |

## Verification
The bench builds the block with DEPTH = 4, ID_W = 8 and NS_W = 30. A depth this small lets a few pushes fill the queue and reach the drop-on-full and sticky-overflow paths. The default one-second period and half-second window are kept, so the exact window boundary at 500,000,000 ns and the rollover at 10^9 are both tested. The bench drives now_ns directly rather than letting a clock run, which places the lateness exactly at the tolerance and one nanosecond beyond it.

// File: rtl/launch_gate.sv
module launch_gate #(
  parameter int DEPTH      = 8,
  parameter int ID_W       = 8,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  input  logic [ID_W-1:0] push_id,
  input  logic [NS_W-1:0] push_ns,
  input  logic [NS_W-1:0] now_ns,
  input  logic [NS_W-1:0] late_tol,
  input  logic [NS_W-1:0] rx_ts_ns,
  input  logic [NS_W-1:0] reply_delay,
  output logic [NS_W-1:0] reply_ns,
  output logic            rel_valid,
  output logic [ID_W-1:0] rel_id,
  output logic            rel_late,
  output logic            full,
  output logic            overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam int SW = NS_W + 1;
  localparam logic [SW-1:0] SEC  = SW'(NS_PER_SEC);
  localparam logic [SW-1:0] HALF = SW'(NS_PER_SEC / 2);

  logic [ID_W-1:0] id_q [DEPTH];
  logic [NS_W-1:0] t_q  [DEPTH];
  logic [PW-1:0]   rp, wp;
  logic [CW-1:0]   cnt;
  logic [SW-1:0]   ahead, behind, rsum;
  logic            fire, do_push, waiting;

  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push_valid && !full;

  always_comb begin
    if (t_q[rp] >= now_ns) ahead = {1'b0, t_q[rp]} - {1'b0, now_ns};
    else                   ahead = {1'b0, t_q[rp]} + SEC - {1'b0, now_ns};
    behind  = (ahead == '0) ? '0 : SEC - ahead;
    waiting = (ahead != '0) && (ahead <= HALF);
    fire    = (cnt != '0) && !waiting;
  end

  assign rsum     = {1'b0, rx_ts_ns} + {1'b0, reply_delay};
  assign reply_ns = (rsum >= SEC) ? NS_W'(rsum - SEC) : NS_W'(rsum);

  always_ff @(posedge clk) begin
    if (do_push) begin
      id_q[wp] <= push_id;
      t_q[wp]  <= push_ns;
    end
    if (!rst_n) begin
      rp        <= '0;
      wp        <= '0;
      cnt       <= '0;
      rel_valid <= 1'b0;
      rel_id    <= '0;
      rel_late  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (fire)    rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt       <= cnt + CW'(do_push) - CW'(fire);
      rel_valid <= fire;
      rel_id    <= fire ? id_q[rp] : rel_id;
      rel_late  <= fire && (behind > {1'b0, late_tol});
      if (push_valid && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/launch_gate_chk.sv
module launch_gate_chk #(
  parameter int NS_W = 30,
  parameter int CW   = 4,
  parameter int SEC  = 1_000_000_000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push_valid,
  input logic            full,
  input logic            overflow,
  input logic            rel_valid,
  input logic            rel_late,
  input logic [NS_W-1:0] reply_ns,
  input logic [CW-1:0]   cnt
);
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_drop_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid) |=> overflow);
  p_late_with_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_late |-> rel_valid);
  p_release_needs_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_valid) |-> $past(cnt) != '0);
  p_reply_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, reply_ns} < (NS_W+1)'(SEC));
  p_full_holds_without_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rel_valid && $past(full)) |-> $stable(cnt));
endmodule

bind launch_gate launch_gate_chk #(.NS_W(NS_W), .CW(CW), .SEC(NS_PER_SEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .full(full),
  .overflow(overflow), .rel_valid(rel_valid), .rel_late(rel_late),
  .reply_ns(reply_ns), .cnt(cnt)
);

// File: tb/launch_gate_tb_top.sv
module launch_gate_tb_top;
  localparam int DEPTH = 4, ID_W = 8, NS_W = 30;

  logic clk = 0, rst_n = 0, push_valid = 0;
  logic [ID_W-1:0] push_id = '0;
  logic [NS_W-1:0] push_ns = '0, now_ns = '0, late_tol = '0;
  logic [NS_W-1:0] rx_ts_ns = '0, reply_delay = '0, reply_ns;
  logic rel_valid, rel_late, full, overflow;
  logic [ID_W-1:0] rel_id;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  launch_gate #(.DEPTH(DEPTH), .ID_W(ID_W), .NS_W(NS_W)) dut_i (.*);

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_rel(input string req, input int id, input bit late);
    chk(rel_valid == 1, req, rel_valid, 1);
    chk(rel_id == id[ID_W-1:0], req, rel_id, id);
    chk(rel_late == late, {req, " late"}, rel_late, late);
  endtask

  task automatic expect_none(input string req);
    chk(rel_valid == 0, req, rel_valid, 0);
  endtask

  task automatic push(input int id, input int t);
    push_valid = 1; push_id = id[ID_W-1:0]; push_ns = t[NS_W-1:0];
    step();
    push_valid = 0;
  endtask

  task automatic t_reset();
    chk(rel_valid == 0 && rel_late == 0, "R1 release", rel_valid, 0);
    chk(full == 0 && overflow == 0, "R1 flags", {full, overflow}, 0);
  endtask

  task automatic t_wait_then_release();
    late_tol = 10; now_ns = 500;
    push(1, 1000);
    for (int i = 0; i < 3; i++) begin step(); expect_none("R2 hold"); end
    now_ns = 1000; step();
    expect_rel("R3 on time", 1, 0);
    step(); expect_none("R9 single strobe");
  endtask

  task automatic t_wrap();
    now_ns = 999_999_900;
    push(2, 100);
    step(); expect_none("R2 across rollover");
    now_ns = 100; step();
    expect_rel("R3 after rollover", 2, 0);
  endtask

  task automatic t_window_edge();
    late_tol = 10; now_ns = 0;
    push(3, 600_000_000);
    step(); expect_rel("R3 beyond half window", 3, 1);
    push(4, 500_000_000);
    step(); expect_none("R2 at half window");
    now_ns = 500_000_000; step();
    expect_rel("R3 at target", 4, 0);
  endtask

  task automatic t_late_boundary();
    late_tol = 50; now_ns = 1050;
    push(5, 1000); step(); expect_rel("R4 equal tolerance", 5, 0);
    now_ns = 1051;
    push(6, 1000); step(); expect_rel("R4 past tolerance", 6, 1);
  endtask

  task automatic t_order();
    late_tol = 1000; now_ns = 0;
    push(20, 300);
    push(21, 0);
    step(); expect_none("R5 head blocks");
    now_ns = 300; step();
    expect_rel("R5 first", 20, 0);
    step(); expect_rel("R5 second", 21, 0);
    step(); expect_none("R9 drained");
  endtask

  task automatic t_full();
    now_ns = 0; late_tol = 1000;
    for (int i = 0; i < 4; i++) push(10 + i, 100);
    chk(full == 1, "R6 full", full, 1);
    chk(overflow == 0, "R7 no drop yet", overflow, 0);
    push(14, 100);
    chk(overflow == 1, "R7 drop flagged", overflow, 1);
    now_ns = 100;
    for (int i = 0; i < 4; i++) begin step(); expect_rel("R7 kept entries", 10 + i, 0); end
    chk(full == 0, "R6 not full", full, 0);
    step(); expect_none("R7 dropped entry absent");
    chk(overflow == 1, "R7 sticky", overflow, 1);
  endtask

  task automatic t_reply();
    rx_ts_ns = 999_999_990; reply_delay = 20; #1;
    chk(reply_ns == 10, "R8 wrap", reply_ns, 10);
    rx_ts_ns = 5; reply_delay = 7; #1;
    chk(reply_ns == 12, "R8 plain", reply_ns, 12);
    rx_ts_ns = 999_999_000; reply_delay = 1000; #1;
    chk(reply_ns == 0, "R8 exact second", reply_ns, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_wait_then_release();
    t_wrap();
    t_window_edge();
    t_late_boundary();
    t_order();
    t_full();
    t_reply();
    finish_run();
  end
endmodule